// File: doc/BRIEF.md
# Complementary PWM Output Stage with Dead Time and Fault Override

This block turns the count value and direction of an external timer base into one pair of complementary PWM pins per channel. Each channel holds two compare points. The up-count point switches the channel's reference high while the counter rises, and the down-count point switches it low while the counter falls. Because the two points are independent, the pulse does not have to be centred in the period.

Software-side writes land in a shadow copy and become active only when the timer base signals its zero or load boundary. A break-before-make stage places a programmable wait between one pin of a pair turning off and the other turning on. The rising and falling edges of the reference have separate wait lengths. A reference pulse that does not outlast its wait never reaches the true pin.

A fault input is captured in a sticky latch. While the latch is set, or during the cycle in which the fault input is first seen, every pin is driven to its own programmed safe level. The latch releases only on an explicit clear strobe given while the fault input is low.

Top module: `pwm_dt_stage`

## Requirements
- R1: While `rst` is high, all `pwm_hi` and `pwm_lo` bits and `fault_active` are 0. On the first clock after release with no compare match, every `pwm_lo` bit is 1.
- R2: A clock edge that sees `cnt_up`=1 and `cnt_val` equal to a channel's active up-count compare value sets that channel's reference high.
- R3: A clock edge that sees `cnt_up`=0 and `cnt_val` equal to the channel's active down-count compare value sets the reference low. The two compare values may differ.
- R4: A write (`wr_en`=1) updates only the shadow pair of channel `wr_ch`. Both active values change only on the edge after an edge that sees `cnt_zero`=1. Until then, the outputs follow the old active values.
- R5: When the reference rises at edge k, `pwm_lo` goes low after edge k+1 and `pwm_hi` goes high after edge k+2+`dt_rise`.
- R6: When the reference falls at edge k, `pwm_hi` goes low after edge k+1 and `pwm_lo` goes high after edge k+2+`dt_fall`.
- R7: A reference high interval of at most `dt_rise`+1 cycles produces no pulse at all on `pwm_hi`.
- R8: An edge that sees `fault_in`=1 sets `fault_active`. After that same edge, `pwm_hi` equals `safe_hi` and `pwm_lo` equals `safe_lo` for every channel.
- R9: `fault_active` stays set until an edge sees `fault_clr`=1 with `fault_in`=0. A clear given while `fault_in` is high is ignored. The pins stay at their safe levels through the clear edge and return to normal PWM one edge later.
- R10: `pwm_hi[i]` and `pwm_lo[i]` are never 1 together. If both safe bits of a channel are 1, the channel drives `pwm_hi`=1 and `pwm_lo`=0 during a fault.
- R11: Channels are independent. Writes and compare matches of one channel leave the pins of every other channel unchanged.
- R12: With both dead times at 0, the pins of a pair switch with exactly one cycle in which both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Current count from the timer base |
| cnt_up | input | 1 | 1 while counting up, 0 while counting down |
| cnt_zero | input | 1 | Zero/load boundary strobe; moves shadow compare values to active |
| wr_en | input | 1 | Shadow compare write strobe |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_up | input | CNT_W | Up-count compare value to write |
| wr_dn | input | CNT_W | Down-count compare value to write |
| dt_rise | input | DT_W | Wait, in clocks, before the true pin turns on |
| dt_fall | input | DT_W | Wait, in clocks, before the complementary pin turns on |
| fault_in | input | 1 | Fault condition, active high |
| fault_clr | input | 1 | Fault latch clear strobe |
| safe_hi | input | NUM_CH | Safe level of each true pin |
| safe_lo | input | NUM_CH | Safe level of each complementary pin |
| pwm_hi | output | NUM_CH | True PWM pins |
| pwm_lo | output | NUM_CH | Complementary PWM pins |
| fault_active | output | 1 | Fault latch state |

## Verification
The hardest behaviour to reach from the ports is suppression of a pulse shorter than the rising dead time. That needs the up-count and down-count matches to fall only a few cycles apart. The bench drives the counter itself, so it places the up-count compare near the top of an up/down sweep and the down-count compare just past the turnaround. This gives a reference pulse of a known, short width. The fault clear sequence is also hard to reach, because a clear strobe can coincide with an active fault input. It is walked cycle by cycle from a vector table that includes both the ignored clear and the two-step return to normal output.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } pin_pair_t;

  // Resolves a requested safe pair so the two pins are never both high.
  function automatic pin_pair_t resolve_safe(input logic want_hi, input logic want_lo);
    pin_pair_t p;
    p.hi = want_hi;
    p.lo = want_lo & ~want_hi;
    return p;
  endfunction

endpackage

// File: rtl/cmp_bank.sv
module cmp_bank #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int CH_W   = 2
)(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [CH_W-1:0]                wr_ch,
  input  logic [CNT_W-1:0]               wr_up,
  input  logic [CNT_W-1:0]               wr_dn,
  input  logic                           load,
  output logic [NUM_CH-1:0][CNT_W-1:0]   act_up,
  output logic [NUM_CH-1:0][CNT_W-1:0]   act_dn
);

  logic [NUM_CH-1:0][CNT_W-1:0] shd_up;
  logic [NUM_CH-1:0][CNT_W-1:0] shd_dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_up <= '0;
      shd_dn <= '0;
      act_up <= '0;
      act_dn <= '0;
    end else begin
      if (wr_en && (int'(wr_ch) < NUM_CH)) begin
        shd_up[wr_ch] <= wr_up;
        shd_dn[wr_ch] <= wr_dn;
      end
      if (load) begin
        act_up <= shd_up;
        act_dn <= shd_dn;
      end
    end
  end

  // R4: active compare values move only after a boundary strobe
  a_r4_hold_until_boundary: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(act_up) && $stable(act_dn)));

endmodule

// File: rtl/pwm_edge.sv
module pwm_edge #(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_up,
  input  logic [CNT_W-1:0] cmp_up,
  input  logic [CNT_W-1:0] cmp_dn,
  output logic             ref_o
);

  logic hit_up;
  logic hit_dn;

  assign hit_up = cnt_up  && (cnt_val == cmp_up);
  assign hit_dn = !cnt_up && (cnt_val == cmp_dn);

  always_ff @(posedge clk) begin
    if (rst)         ref_o <= 1'b0;
    else if (hit_up) ref_o <= 1'b1;
    else if (hit_dn) ref_o <= 1'b0;
  end

  // R2: up-count match raises the reference
  a_r2_set_on_up_match: assert property (@(posedge clk) disable iff (rst)
    (cnt_up && (cnt_val == cmp_up)) |=> ref_o);

  // R3: down-count match lowers the reference
  a_r3_clear_on_down_match: assert property (@(posedge clk) disable iff (rst)
    (!cnt_up && (cnt_val == cmp_dn)) |=> !ref_o);

endmodule

// File: rtl/dead_band.sv
module dead_band #(
  parameter int DT_W = 8
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dt_rise,
  input  logic [DT_W-1:0] dt_fall,
  output logic            raw_hi,
  output logic            raw_lo
);

  logic            ref_d;
  logic            pending;
  logic [DT_W-1:0] dly;
  logic            idle;

  assign pending = ref_i ^ ref_d;
  assign idle    = (dly == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_d <= 1'b0;
      dly   <= '0;
    end else begin
      ref_d <= ref_i;
      if (pending)
        dly <= ref_i ? dt_rise : dt_fall;
      else if (!idle)
        dly <= dly - DT_W'(1);
    end
  end

  // A pin turns on only once the reference is settled and the wait has run out.
  assign raw_hi =  ref_i & ~pending & idle;
  assign raw_lo = ~ref_i & ~pending & idle;

endmodule

// File: rtl/fault_latch.sv
module fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic fault_in,
  input  logic fault_clr,
  output logic fault_q
);

  always_ff @(posedge clk) begin
    if (rst)            fault_q <= 1'b0;
    else if (fault_in)  fault_q <= 1'b1;
    else if (fault_clr) fault_q <= 1'b0;
  end

  // R8: a seen fault is captured
  a_r8_capture: assert property (@(posedge clk) disable iff (rst)
    fault_in |=> fault_q);

  // R9: the latch holds without a valid clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !(fault_clr && !fault_in)) |=> fault_q);

  // R9: a clear with the fault input low releases the latch
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    (fault_clr && !fault_in) |=> !fault_q);

endmodule

// File: rtl/pwm_dt_stage.sv
module pwm_dt_stage
  import pwm_dt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int DT_W   = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_up,
  input  logic              cnt_zero,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [CNT_W-1:0]  wr_up,
  input  logic [CNT_W-1:0]  wr_dn,
  input  logic [DT_W-1:0]   dt_rise,
  input  logic [DT_W-1:0]   dt_fall,
  input  logic              fault_in,
  input  logic              fault_clr,
  input  logic [NUM_CH-1:0] safe_hi,
  input  logic [NUM_CH-1:0] safe_lo,
  output logic [NUM_CH-1:0] pwm_hi,
  output logic [NUM_CH-1:0] pwm_lo,
  output logic              fault_active
);

  logic [NUM_CH-1:0][CNT_W-1:0] act_up;
  logic [NUM_CH-1:0][CNT_W-1:0] act_dn;
  logic [NUM_CH-1:0]            ref_w;
  logic [NUM_CH-1:0]            raw_hi;
  logic [NUM_CH-1:0]            raw_lo;
  logic [NUM_CH-1:0]            safe_hi_eff;
  logic [NUM_CH-1:0]            safe_lo_eff;
  logic                         force_safe;

  cmp_bank #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .CH_W   (CH_W)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_ch  (wr_ch),
    .wr_up  (wr_up),
    .wr_dn  (wr_dn),
    .load   (cnt_zero),
    .act_up (act_up),
    .act_dn (act_dn)
  );

  fault_latch u_fault (
    .clk       (clk),
    .rst       (rst),
    .fault_in  (fault_in),
    .fault_clr (fault_clr),
    .fault_q   (fault_active)
  );

  // The raw fault input forces the pins on the very edge it is first seen.
  assign force_safe = fault_in | fault_active;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      pwm_edge #(.CNT_W(CNT_W)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .cnt_val (cnt_val),
        .cnt_up  (cnt_up),
        .cmp_up  (act_up[i]),
        .cmp_dn  (act_dn[i]),
        .ref_o   (ref_w[i])
      );

      dead_band #(.DT_W(DT_W)) u_db (
        .clk     (clk),
        .rst     (rst),
        .ref_i   (ref_w[i]),
        .dt_rise (dt_rise),
        .dt_fall (dt_fall),
        .raw_hi  (raw_hi[i]),
        .raw_lo  (raw_lo[i])
      );

      // R5: outside fault transitions the true pin turns on only after the complement was off
      a_r5_gap_before_true: assert property (@(posedge clk) disable iff (rst)
        (!fault_active && !$past(fault_active) && !$past(fault_active, 2) && $rose(pwm_hi[i]))
        |-> $past(!pwm_lo[i]));

      // R6: outside fault transitions the complement turns on only after the true pin was off
      a_r6_gap_before_comp: assert property (@(posedge clk) disable iff (rst)
        (!fault_active && !$past(fault_active) && !$past(fault_active, 2) && $rose(pwm_lo[i]))
        |-> $past(!pwm_hi[i]));
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      pin_pair_t pp;
      pp = resolve_safe(safe_hi[i], safe_lo[i]);
      safe_hi_eff[i] = pp.hi;
      safe_lo_eff[i] = pp.lo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_hi <= '0;
      pwm_lo <= '0;
    end else if (force_safe) begin
      pwm_hi <= safe_hi_eff;
      pwm_lo <= safe_lo_eff;
    end else begin
      pwm_hi <= raw_hi;
      pwm_lo <= raw_lo;
    end
  end

  // R1: reset leaves every pin and the fault flag low
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> ((pwm_hi == '0) && (pwm_lo == '0) && !fault_active));

  // R10: the two pins of a pair are never high together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    (pwm_hi & pwm_lo) == '0);

  // R8: a latched fault shows the programmed safe levels on the pins
  a_r8_safe_levels: assert property (@(posedge clk) disable iff (rst)
    fault_active |-> ((pwm_hi == $past(safe_hi)) && ((pwm_lo & ~$past(safe_lo)) == '0)));

endmodule

// File: tb/test_pwm_dt_stage.sv
module test_pwm_dt_stage;

  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;
  localparam int DT_W   = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic [CNT_W-1:0]  cnt_val;
  logic              cnt_up;
  logic              cnt_zero;
  logic              wr_en;
  logic [1:0]        wr_ch;
  logic [CNT_W-1:0]  wr_up;
  logic [CNT_W-1:0]  wr_dn;
  logic [DT_W-1:0]   dt_rise;
  logic [DT_W-1:0]   dt_fall;
  logic              fault_in;
  logic              fault_clr;
  logic [NUM_CH-1:0] safe_hi;
  logic [NUM_CH-1:0] safe_lo;
  logic [NUM_CH-1:0] pwm_hi;
  logic [NUM_CH-1:0] pwm_lo;
  logic              fault_active;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  logic [NUM_CH-1:0] hlog [0:59];
  logic [NUM_CH-1:0] llog [0:59];

  // fault vectors: {fault_in, fault_clr, exp fault_active, exp pwm_hi[3:0], exp pwm_lo[3:0]}
  // safe_hi = 0011, safe_lo = 0110: channel 1 asks for both high, so its complement reads 0
  localparam logic [10:0] FVEC [0:9] = '{
    11'b0_0_0_0000_1111,
    11'b1_0_1_0011_0100,
    11'b0_0_1_0011_0100,
    11'b1_1_1_0011_0100,
    11'b0_0_1_0011_0100,
    11'b0_1_0_0011_0100,
    11'b0_0_0_0000_1111,
    11'b1_1_1_0011_0100,
    11'b0_1_0_0011_0100,
    11'b0_0_0_0000_1111
  };

  always #4 clk = ~clk;

  pwm_dt_stage #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .DT_W   (DT_W)
  ) i_pwm_dt_stage (
    .clk          (clk),
    .rst          (rst),
    .cnt_val      (cnt_val),
    .cnt_up       (cnt_up),
    .cnt_zero     (cnt_zero),
    .wr_en        (wr_en),
    .wr_ch        (wr_ch),
    .wr_up        (wr_up),
    .wr_dn        (wr_dn),
    .dt_rise      (dt_rise),
    .dt_fall      (dt_fall),
    .fault_in     (fault_in),
    .fault_clr    (fault_clr),
    .safe_hi      (safe_hi),
    .safe_lo      (safe_lo),
    .pwm_hi       (pwm_hi),
    .pwm_lo       (pwm_lo),
    .fault_active (fault_active)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [CNT_W-1:0] v, input logic up, input logic z);
    cnt_val  = v;
    cnt_up   = up;
    cnt_zero = z;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_ch(input logic [1:0] ch, input logic [CNT_W-1:0] up, input logic [CNT_W-1:0] dn);
    wr_en = 1'b1;
    wr_ch = ch;
    wr_up = up;
    wr_dn = dn;
    cyc(16'd100, 1'b0, 1'b0);
    wr_en = 1'b0;
  endtask

  // 30 cycles counting up 1..30, then 30 cycles counting down 30..1
  task automatic sweep();
    for (int s = 0; s < 60; s++) begin
      if (s < 30) cyc(CNT_W'(s + 1), 1'b1, 1'b0);
      else        cyc(CNT_W'(60 - s), 1'b0, 1'b0);
      hlog[s] = pwm_hi;
      llog[s] = pwm_lo;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cnt_val = 16'd100; cnt_up = 1'b0; cnt_zero = 1'b0;
    wr_en = 1'b0; wr_ch = 2'd0; wr_up = '0; wr_dn = '0;
    dt_rise = 8'd3; dt_fall = 8'd2; fault_in = 1'b0; fault_clr = 1'b0;
    safe_hi = 4'b0011; safe_lo = 4'b0110;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(pwm_hi == 4'b0000, "R1 reset pwm_hi", int'(pwm_hi), 0);
    check(pwm_lo == 4'b0000, "R1 reset pwm_lo", int'(pwm_lo), 0);
    check(fault_active == 1'b0, "R1 reset fault_active", int'(fault_active), 0);
    rst = 1'b0;
    cyc(16'd100, 1'b0, 1'b0);
    check(pwm_lo == 4'b1111, "R1 first cycle pwm_lo", int'(pwm_lo), 15);
    check(pwm_hi == 4'b0000, "R1 first cycle pwm_hi", int'(pwm_hi), 0);

    // R4: shadow write not used before a boundary strobe
    write_ch(2'd0, 16'd10, 16'd20);
    for (int v = 1; v <= 15; v++) begin
      cyc(CNT_W'(v), 1'b1, 1'b0);
      check(pwm_hi[0] == 1'b0 && pwm_lo[0] == 1'b1, "R4 shadow held pwm_hi[0]", int'(pwm_hi[0]), 0);
    end
    cyc(16'd100, 1'b0, 1'b1);

    // Sweep 1: up=10 (match at step 9), down=20 (match at step 40), dt_rise 3, dt_fall 2
    sweep();
    check(llog[9]  == 4'b1111, "R2 complement high before set", int'(llog[9]), 15);
    check(llog[10][0] == 1'b0, "R2 R5 complement off one edge after set", int'(llog[10][0]), 0);
    check(hlog[13][0] == 1'b0, "R5 true still off in dead time", int'(hlog[13][0]), 0);
    check(hlog[14][0] == 1'b1, "R5 true on after dt_rise", int'(hlog[14][0]), 1);
    check(hlog[40][0] == 1'b1, "R3 true high before clear", int'(hlog[40][0]), 1);
    check(hlog[41][0] == 1'b0, "R3 R6 true off one edge after clear", int'(hlog[41][0]), 0);
    check(llog[43][0] == 1'b0, "R6 complement still off in dead time", int'(llog[43][0]), 0);
    check(llog[44][0] == 1'b1, "R6 complement on after dt_fall", int'(llog[44][0]), 1);
    begin
      int ovl = 0;
      int oth = 0;
      for (int s = 0; s < 60; s++) begin
        if ((hlog[s] & llog[s]) != 4'b0000) ovl++;
        if (hlog[s][3:1] != 3'b000 || llog[s][3:1] != 3'b111) oth++;
      end
      check(ovl == 0, "R10 overlap cycles in sweep", ovl, 0);
      check(oth == 0, "R11 other channels disturbed", oth, 0);
    end

    // Sweep 2: short pulse, up=27 (step 26), down=28 (step 32), dt_rise 8
    dt_rise = 8'd8;
    write_ch(2'd0, 16'd27, 16'd28);
    cyc(16'd100, 1'b0, 1'b1);
    sweep();
    begin
      int hi_cnt = 0;
      for (int s = 0; s < 60; s++) if (hlog[s][0]) hi_cnt++;
      check(hi_cnt == 0, "R7 short pulse on true pin", hi_cnt, 0);
    end
    check(llog[27][0] == 1'b0, "R7 complement off for short pulse", int'(llog[27][0]), 0);
    check(llog[35][0] == 1'b0, "R7 R6 complement waits dt_fall", int'(llog[35][0]), 0);
    check(llog[36][0] == 1'b1, "R7 R6 complement back on", int'(llog[36][0]), 1);

    // Sweep 3: zero dead times
    dt_rise = 8'd0;
    dt_fall = 8'd0;
    write_ch(2'd0, 16'd10, 16'd20);
    cyc(16'd100, 1'b0, 1'b1);
    sweep();
    check(llog[9][0] == 1'b1 && hlog[9][0] == 1'b0, "R12 before set", int'(llog[9][0]), 1);
    check(llog[10][0] == 1'b0 && hlog[10][0] == 1'b0, "R12 single both-low cycle on rise", int'(hlog[10][0]), 0);
    check(hlog[11][0] == 1'b1, "R12 true on next cycle", int'(hlog[11][0]), 1);
    check(hlog[41][0] == 1'b0 && llog[41][0] == 1'b0, "R12 single both-low cycle on fall", int'(llog[41][0]), 0);
    check(llog[42][0] == 1'b1, "R12 complement on next cycle", int'(llog[42][0]), 1);

    // Fault vector walk: R8 capture, R9 stickiness and clear, R10 safe pair resolution
    for (int r = 0; r < 10; r++) begin
      fault_in  = FVEC[r][10];
      fault_clr = FVEC[r][9];
      cyc(16'd100, 1'b0, 1'b0);
      check(fault_active == FVEC[r][8], $sformatf("R8 R9 row %0d fault_active", r), int'(fault_active), int'(FVEC[r][8]));
      check(pwm_hi == FVEC[r][7:4], $sformatf("R8 row %0d pwm_hi", r), int'(pwm_hi), int'(FVEC[r][7:4]));
      check(pwm_lo == FVEC[r][3:0], $sformatf("R8 R10 row %0d pwm_lo", r), int'(pwm_lo), int'(FVEC[r][3:0]));
    end
    fault_in  = 1'b0;
    fault_clr = 1'b0;

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule